// File: doc/BRIEF.md
# Quad DAC SPI Register Interface

This block is the serial register front end of a four-channel digital-to-analog converter. A host drives 24-bit words over a four-wire serial link in clock mode 1. The line is idle low, the host changes its output on the rising edge, and the block samples on the falling edge. Each word is either a register write or a read request. The block keeps a code, a gain and an offset word for every channel. Every channel also has a per-channel output-control word and a ramp (slew) configuration. Two shared words, a main configuration and a boost-converter configuration, complete the set. All of these drive the analog and calibration logic downstream as plain buses.

A word counts only when the select line rises after exactly 24 falling clock edges. Reads are split across two words. The request word names a register in a read-side address map, which is laid out differently from the write map. The requested value then comes back on the output line during the next word, which is normally a word that does nothing.

The select line must stay high for at least three system clock cycles between words. While it is low, each serial clock level must be held for at least two system clock cycles. The serial inputs are sampled directly by the system clock and are expected to be synchronous to it.

Top module: `qdac_spi_regs`

## Requirements
- R1: A word is captured most significant bit first, one bit per falling serial-clock edge while select is low. Its fields are: bit 23 is the read flag, bits 20:16 are the address, bits 15:0 are the data, and bits 22:21 are ignored. A word is acted on only when select rises after exactly 24 falling edges.
- R2: A word of any other length changes no register. The word that follows it returns all zeros.
- R3: A write (bit 23 = 0) to address 0x00–0x03 sets the code word of channel addr[1:0]. Addresses 0x08–0x0B set the gain word and 0x10–0x13 set the offset word, in the same way. The code, gain and offset buses put channel n at bits 16n+15:16n.
- R4: A write to 0x1C–0x1F is a control write for channel addr[1:0], and data bits 15:13 select its target. Selector 0 stores data bits 12:0 as the channel's slew word: bit 12 enables, bits 6:3 give the rate, bits 2:0 give the step. Selector 2 stores data bits 8:0 as the channel's output-control word: bits 2:0 give the range, bit 3 over-range, bit 4 boost enable, bit 5 internal sense resistor, bit 6 output enable, bit 7 clear enable, bit 8 internal enable. Channel n sits at bits 9n+8:9n and 13n+12:13n of the respective buses.
- R5: Control selector 1 stores data bits 12:0 as the shared main word. Selector 3 stores data bits 6:0 as the shared boost word: bits 1:0 give the maximum voltage, bits 3:2 the frequency, bits 5:4 the phase, and bit 6 selects the external compensation. Both selectors apply whatever the channel bits are.
- R6: Control selectors 4–7 and writes to any other address change no register. The idle word 0x1CE000 is therefore harmless.
- R7: A read request (bit 23 = 1) changes no register. During the next 24-bit word the output line carries 8 zero bits and then the 16-bit value, most significant bit first. Each bit is presented one system clock after a rising serial-clock edge.
- R8: The read map is as follows. 0x00–0x03 return the code, 0x04–0x07 the output-control word zero-extended, 0x08–0x0B the gain, 0x0C–0x0F the offset, and 0x14–0x17 the slew word zero-extended, each for channel addr[1:0]. 0x19 returns the main word and 0x1A the boost word. 0x10–0x13, 0x18 and 0x1B–0x1F return zero.
- R9: After any complete word that is not a read request, the next word returns all zeros.
- R10: Reset clears every register and the output line to zero.
- R11: A committed write shows on the outputs two system clocks after select rises. At most one register changes per word, and none changes while select stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low word select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| dac_code | output | 64 | Per-channel output codes |
| dac_gain | output | 64 | Per-channel gain words |
| dac_offset | output | 64 | Per-channel offset words |
| dac_ctrl | output | 36 | Per-channel output-control words |
| dac_slew | output | 52 | Per-channel slew words |
| main_cfg | output | 13 | Shared main configuration |
| boost_cfg | output | 7 | Shared boost-converter configuration |

## Verification
The properties assume that the serial clock is low during reset. They also assume that select stays high for at least three system clocks between words, so that a commit never overlaps the next word's first edges. The stimulus drives every serial-clock level for two system clocks and always leaves a three-cycle select gap. Deliberately short and long words, and words with the read flag set, are sent only through that same timing.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int NUM_CH      = 4;
    localparam int CH_W        = $clog2(NUM_CH);
    localparam int WORD_W      = 16;
    localparam int ADDR_W      = 5;
    localparam int FRAME_W     = 24;
    localparam int CNT_W       = $clog2(FRAME_W + 2);
    localparam int RD_FLAG_BIT = FRAME_W - 1;
    localparam int ADDR_LSB    = WORD_W;
    localparam int PAD_W       = FRAME_W - WORD_W;
    localparam int REGION_W    = ADDR_W - CH_W;

    localparam int DCTL_W = 9;
    localparam int SLEW_W = 13;
    localparam int MAIN_W = 13;
    localparam int BST_W  = 7;
    localparam int SEL_W  = 3;
    localparam int SEL_LSB = WORD_W - SEL_W;

    // write-side regions, selected by addr[4:2]
    localparam logic [REGION_W-1:0] WR_CODE = 3'b000;
    localparam logic [REGION_W-1:0] WR_GAIN = 3'b010;
    localparam logic [REGION_W-1:0] WR_OFFS = 3'b100;
    localparam logic [REGION_W-1:0] WR_CTRL = 3'b111;

    // read-side regions, selected by addr[4:2]
    localparam logic [REGION_W-1:0] RD_CODE = 3'b000;
    localparam logic [REGION_W-1:0] RD_DCTL = 3'b001;
    localparam logic [REGION_W-1:0] RD_GAIN = 3'b010;
    localparam logic [REGION_W-1:0] RD_OFFS = 3'b011;
    localparam logic [REGION_W-1:0] RD_SLEW = 3'b101;
    localparam logic [REGION_W-1:0] RD_GLOB = 3'b110;
    localparam logic [CH_W-1:0]     GLOB_MAIN = 2'd1;
    localparam logic [CH_W-1:0]     GLOB_BST  = 2'd2;

    // control sub-register selectors
    localparam logic [SEL_W-1:0] SEL_SLEW = 3'd0;
    localparam logic [SEL_W-1:0] SEL_MAIN = 3'd1;
    localparam logic [SEL_W-1:0] SEL_DCTL = 3'd2;
    localparam logic [SEL_W-1:0] SEL_BST  = 3'd3;
endpackage

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx
    import qdac_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               cs_n,
    input  logic               mosi,
    input  logic [WORD_W-1:0]  reply_word,
    output logic               frame_end,
    output logic               frame_ok,
    output logic [FRAME_W-1:0] frame_word,
    output logic               miso
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic               sclk_prev;
        logic               cs_prev_n;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] rx;
        logic [FRAME_W-1:0] tx;
        logic               miso;
        logic               done;
        logic               ok;
        logic [FRAME_W-1:0] word;
    } rx_state_t;

    rx_state_t s_d, s_q;
    logic      edge_rise, edge_fall, cs_rise;

    always_comb begin
        s_d           = s_q;
        s_d.sclk_prev = sclk;
        s_d.cs_prev_n = cs_n;
        s_d.done      = 1'b0;

        edge_rise = sclk & ~s_q.sclk_prev & ~cs_n;
        edge_fall = ~sclk & s_q.sclk_prev & ~cs_n;
        cs_rise   = cs_n & ~s_q.cs_prev_n;

        if (edge_fall) begin
            s_d.rx = {s_q.rx[FRAME_W-2:0], mosi};
            if (s_q.cnt != CNT_SAT) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end

        if (edge_rise) begin
            s_d.miso = s_q.tx[FRAME_W-1];
            s_d.tx   = {s_q.tx[FRAME_W-2:0], 1'b0};
        end

        if (cs_rise) begin
            s_d.done = 1'b1;
            s_d.ok   = (s_q.cnt == CNT_FULL);
            s_d.word = s_q.rx;
            s_d.cnt  = '0;
        end

        // reply for the next word is loaded in the commit cycle
        if (s_q.done) begin
            s_d.tx = {{PAD_W{1'b0}}, reply_word};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.cs_prev_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_end  = s_q.done;
    assign frame_ok   = s_q.ok;
    assign frame_word = s_q.word;
    assign miso       = s_q.miso;
endmodule

// File: rtl/qdac_regfile.sv
module qdac_regfile
    import qdac_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [NUM_CH*WORD_W-1:0]  code_o,
    output logic [NUM_CH*WORD_W-1:0]  gain_o,
    output logic [NUM_CH*WORD_W-1:0]  offs_o,
    output logic [NUM_CH*DCTL_W-1:0]  dctl_o,
    output logic [NUM_CH*SLEW_W-1:0]  slew_o,
    output logic [MAIN_W-1:0]         main_o,
    output logic [BST_W-1:0]          bst_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][WORD_W-1:0] code;
        logic [NUM_CH-1:0][WORD_W-1:0] gain;
        logic [NUM_CH-1:0][WORD_W-1:0] offs;
        logic [NUM_CH-1:0][DCTL_W-1:0] dctl;
        logic [NUM_CH-1:0][SLEW_W-1:0] slew;
        logic [MAIN_W-1:0]             main;
        logic [BST_W-1:0]              bst;
    } regs_t;

    regs_t            r_d, r_q;
    logic [CH_W-1:0]  ch;
    logic [REGION_W-1:0] region;
    logic [SEL_W-1:0] sel;

    always_comb begin
        r_d    = r_q;
        ch     = wr_addr[CH_W-1:0];
        region = wr_addr[ADDR_W-1:CH_W];
        sel    = wr_data[WORD_W-1:SEL_LSB];

        if (wr_en) begin
            unique case (region)
                WR_CODE: r_d.code[ch] = wr_data;
                WR_GAIN: r_d.gain[ch] = wr_data;
                WR_OFFS: r_d.offs[ch] = wr_data;
                WR_CTRL: begin
                    unique case (sel)
                        SEL_SLEW: r_d.slew[ch] = wr_data[SLEW_W-1:0];
                        SEL_MAIN: r_d.main     = wr_data[MAIN_W-1:0];
                        SEL_DCTL: r_d.dctl[ch] = wr_data[DCTL_W-1:0];
                        SEL_BST:  r_d.bst      = wr_data[BST_W-1:0];
                        default:  ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code_o = r_q.code;
    assign gain_o = r_q.gain;
    assign offs_o = r_q.offs;
    assign dctl_o = r_q.dctl;
    assign slew_o = r_q.slew;
    assign main_o = r_q.main;
    assign bst_o  = r_q.bst;
endmodule

// File: rtl/qdac_readback.sv
module qdac_readback
    import qdac_pkg::*;
(
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [NUM_CH*WORD_W-1:0]  code_i,
    input  logic [NUM_CH*WORD_W-1:0]  gain_i,
    input  logic [NUM_CH*WORD_W-1:0]  offs_i,
    input  logic [NUM_CH*DCTL_W-1:0]  dctl_i,
    input  logic [NUM_CH*SLEW_W-1:0]  slew_i,
    input  logic [MAIN_W-1:0]         main_i,
    input  logic [BST_W-1:0]          bst_i,
    output logic [WORD_W-1:0]         rd_value
);
    logic [WORD_W-1:0] code_a [NUM_CH];
    logic [WORD_W-1:0] gain_a [NUM_CH];
    logic [WORD_W-1:0] offs_a [NUM_CH];
    logic [WORD_W-1:0] dctl_a [NUM_CH];
    logic [WORD_W-1:0] slew_a [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign code_a[g] = code_i[g*WORD_W +: WORD_W];
        assign gain_a[g] = gain_i[g*WORD_W +: WORD_W];
        assign offs_a[g] = offs_i[g*WORD_W +: WORD_W];
        assign dctl_a[g] = WORD_W'(dctl_i[g*DCTL_W +: DCTL_W]);
        assign slew_a[g] = WORD_W'(slew_i[g*SLEW_W +: SLEW_W]);
    end

    logic [CH_W-1:0]     ch;
    logic [REGION_W-1:0] region;

    always_comb begin
        ch       = rd_addr[CH_W-1:0];
        region   = rd_addr[ADDR_W-1:CH_W];
        rd_value = '0;
        unique case (region)
            RD_CODE: rd_value = code_a[ch];
            RD_DCTL: rd_value = dctl_a[ch];
            RD_GAIN: rd_value = gain_a[ch];
            RD_OFFS: rd_value = offs_a[ch];
            RD_SLEW: rd_value = slew_a[ch];
            RD_GLOB: begin
                if (ch == GLOB_MAIN) begin
                    rd_value = WORD_W'(main_i);
                end else if (ch == GLOB_BST) begin
                    rd_value = WORD_W'(bst_i);
                end
            end
            default: rd_value = '0;
        endcase
    end
endmodule

// File: rtl/qdac_spi_regs.sv
module qdac_spi_regs
    import qdac_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      spi_sclk,
    input  logic                      spi_cs_n,
    input  logic                      spi_mosi,
    output logic                      spi_miso,
    output logic [NUM_CH*WORD_W-1:0]  dac_code,
    output logic [NUM_CH*WORD_W-1:0]  dac_gain,
    output logic [NUM_CH*WORD_W-1:0]  dac_offset,
    output logic [NUM_CH*DCTL_W-1:0]  dac_ctrl,
    output logic [NUM_CH*SLEW_W-1:0]  dac_slew,
    output logic [MAIN_W-1:0]         main_cfg,
    output logic [BST_W-1:0]          boost_cfg
);
    logic               frame_end;
    logic               frame_ok;
    logic [FRAME_W-1:0] frame_word;
    logic               frame_rd;
    logic [ADDR_W-1:0]  frame_addr;
    logic [WORD_W-1:0]  frame_data;
    logic               wr_en;
    logic [WORD_W-1:0]  rb_value;
    logic [WORD_W-1:0]  reply_word;
    logic               unused_bits;

    assign frame_rd    = frame_word[RD_FLAG_BIT];
    assign frame_addr  = frame_word[ADDR_LSB +: ADDR_W];
    assign frame_data  = frame_word[WORD_W-1:0];
    assign unused_bits = ^frame_word[RD_FLAG_BIT-1:ADDR_LSB+ADDR_W];

    assign wr_en      = frame_end & frame_ok & ~frame_rd;
    assign reply_word = (frame_ok && frame_rd) ? rb_value : '0;

    qdac_frame_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (spi_sclk),
        .cs_n       (spi_cs_n),
        .mosi       (spi_mosi),
        .reply_word (reply_word),
        .frame_end  (frame_end),
        .frame_ok   (frame_ok),
        .frame_word (frame_word),
        .miso       (spi_miso)
    );

    qdac_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (frame_addr),
        .wr_data (frame_data),
        .code_o  (dac_code),
        .gain_o  (dac_gain),
        .offs_o  (dac_offset),
        .dctl_o  (dac_ctrl),
        .slew_o  (dac_slew),
        .main_o  (main_cfg),
        .bst_o   (boost_cfg)
    );

    qdac_readback u_rb (
        .rd_addr  (frame_addr),
        .code_i   (dac_code),
        .gain_i   (dac_gain),
        .offs_i   (dac_offset),
        .dctl_i   (dac_ctrl),
        .slew_i   (dac_slew),
        .main_i   (main_cfg),
        .bst_i    (boost_cfg),
        .rd_value (rb_value)
    );
endmodule

// File: rtl/qdac_spi_regs_chk.sv
module qdac_spi_regs_chk
    import qdac_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      spi_sclk,
    input logic                      spi_cs_n,
    input logic                      spi_miso,
    input logic                      frame_end,
    input logic                      frame_ok,
    input logic                      frame_rd,
    input logic [NUM_CH*WORD_W-1:0]  dac_code,
    input logic [NUM_CH*WORD_W-1:0]  dac_gain,
    input logic [NUM_CH*WORD_W-1:0]  dac_offset,
    input logic [NUM_CH*DCTL_W-1:0]  dac_ctrl,
    input logic [NUM_CH*SLEW_W-1:0]  dac_slew,
    input logic [MAIN_W-1:0]         main_cfg,
    input logic [BST_W-1:0]          boost_cfg
);
    localparam int CHG_W = 5 * NUM_CH + 2;

    logic [NUM_CH*WORD_W-1:0] code_p, gain_p, offs_p;
    logic [NUM_CH*DCTL_W-1:0] dctl_p;
    logic [NUM_CH*SLEW_W-1:0] slew_p;
    logic [MAIN_W-1:0]        main_p;
    logic [BST_W-1:0]         bst_p;
    logic [CHG_W-1:0]         chg;

    always_ff @(posedge clk) begin
        code_p <= dac_code;
        gain_p <= dac_gain;
        offs_p <= dac_offset;
        dctl_p <= dac_ctrl;
        slew_p <= dac_slew;
        main_p <= main_cfg;
        bst_p  <= boost_cfg;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chg
        assign chg[5*g+0] = dac_code[g*WORD_W +: WORD_W]   != code_p[g*WORD_W +: WORD_W];
        assign chg[5*g+1] = dac_gain[g*WORD_W +: WORD_W]   != gain_p[g*WORD_W +: WORD_W];
        assign chg[5*g+2] = dac_offset[g*WORD_W +: WORD_W] != offs_p[g*WORD_W +: WORD_W];
        assign chg[5*g+3] = dac_ctrl[g*DCTL_W +: DCTL_W]   != dctl_p[g*DCTL_W +: DCTL_W];
        assign chg[5*g+4] = dac_slew[g*SLEW_W +: SLEW_W]   != slew_p[g*SLEW_W +: SLEW_W];
    end
    assign chg[5*NUM_CH]   = main_cfg  != main_p;
    assign chg[5*NUM_CH+1] = boost_cfg != bst_p;

    assert_one_register_per_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chg) <= 1);

    assert_hold_while_selected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && $past(!spi_cs_n, 2)) |-> (chg == '0));

    assert_short_or_long_word_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(frame_end && frame_ok) |-> (chg == '0));

    assert_read_request_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_end && frame_rd) |-> (chg == '0));

    assert_miso_moves_after_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(spi_sclk) && !$past(spi_sclk, 2) && !$past(spi_cs_n)) |-> $stable(spi_miso));
endmodule

bind qdac_spi_regs qdac_spi_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_sclk   (spi_sclk),
    .spi_cs_n   (spi_cs_n),
    .spi_miso   (spi_miso),
    .frame_end  (frame_end),
    .frame_ok   (frame_ok),
    .frame_rd   (frame_rd),
    .dac_code   (dac_code),
    .dac_gain   (dac_gain),
    .dac_offset (dac_offset),
    .dac_ctrl   (dac_ctrl),
    .dac_slew   (dac_slew),
    .main_cfg   (main_cfg),
    .boost_cfg  (boost_cfg)
);

// File: tb/qdac_spi_regs_test.sv
`timescale 1ns/1ps
module qdac_spi_regs_test;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic        spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso;
    logic [63:0] dac_code, dac_gain, dac_offset;
    logic [35:0] dac_ctrl;
    logic [51:0] dac_slew;
    logic [12:0] main_cfg;
    logic [6:0]  boost_cfg;

    qdac_spi_regs uut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .dac_code(dac_code),
        .dac_gain(dac_gain), .dac_offset(dac_offset), .dac_ctrl(dac_ctrl),
        .dac_slew(dac_slew), .main_cfg(main_cfg), .boost_cfg(boost_cfg)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit mon_en = 1'b0;

    // behavioural reference state
    logic [15:0] m_code [4];
    logic [15:0] m_gain [4];
    logic [15:0] m_offs [4];
    logic [8:0]  m_dctl [4];
    logic [12:0] m_slew [4];
    logic [12:0] m_main;
    logic [6:0]  m_bst;
    logic [15:0] rb_exp;

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] model_read(int a);
        int c = a % 4;
        if (a < 4)  return m_code[c];
        if (a < 8)  return {7'b0, m_dctl[c]};
        if (a < 12) return m_gain[c];
        if (a < 16) return m_offs[c];
        if (a < 20) return 16'h0;
        if (a < 24) return {3'b0, m_slew[c]};
        if (a == 25) return {3'b0, m_main};
        if (a == 26) return {9'b0, m_bst};
        return 16'h0;
    endfunction

    task automatic model_apply(logic [31:0] w, int n);
        int a = int'(w[20:16]);
        int c = a % 4;
        logic [15:0] d = w[15:0];
        rb_exp = 16'h0;
        if (n != 24) return;
        if (w[23]) begin
            rb_exp = model_read(a);
            return;
        end
        if (a < 4) m_code[c] = d;
        else if (a >= 8 && a < 12) m_gain[c] = d;
        else if (a >= 16 && a < 20) m_offs[c] = d;
        else if (a >= 28) begin
            case (d[15:13])
                3'd0: m_slew[c] = d[12:0];
                3'd1: m_main = d[12:0];
                3'd2: m_dctl[c] = d[8:0];
                3'd3: m_bst = d[6:0];
                default: ;
            endcase
        end
    endtask

    function automatic logic [31:0] mk(logic rd, logic [4:0] addr, logic [15:0] data);
        return {8'h00, rd, 2'b00, addr, data};
    endfunction

    // R1: MSB-first word, one bit per falling edge, mode-1 timing
    task automatic frame(logic [31:0] w, int nbits);
        logic [31:0] got = 32'h0;
        logic [23:0] exp_rx = {8'h00, rb_exp};
        spi_cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) begin
            spi_sclk = 1'b1;
            spi_mosi = w[i];
            repeat (2) @(negedge clk);
            got = {got[30:0], spi_miso};
            spi_sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        spi_cs_n = 1'b1;
        @(negedge clk);
        #1;
        model_apply(w, nbits);
        if (nbits == 24) check("R7/R8/R9 readback", {8'h0, got[23:0]}, {8'h0, exp_rx});
        repeat (3) @(negedge clk);
    endtask

    // R11: outputs compared with the model on every clock
    always @(negedge clk) begin
        if (mon_en) begin
            for (int c = 0; c < 4; c++) begin
                check("R3 code",   32'(dac_code[c*16 +: 16]),   32'(m_code[c]));
                check("R3 gain",   32'(dac_gain[c*16 +: 16]),   32'(m_gain[c]));
                check("R3 offset", 32'(dac_offset[c*16 +: 16]), 32'(m_offs[c]));
                check("R4 dacctl", 32'(dac_ctrl[c*9 +: 9]),     32'(m_dctl[c]));
                check("R4 slew",   32'(dac_slew[c*13 +: 13]),   32'(m_slew[c]));
            end
            check("R5 main",  32'(main_cfg),  32'(m_main));
            check("R5 boost", 32'(boost_cfg), 32'(m_bst));
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; spi_sclk = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
        for (int c = 0; c < 4; c++) begin
            m_code[c] = '0; m_gain[c] = '0; m_offs[c] = '0; m_dctl[c] = '0; m_slew[c] = '0;
        end
        m_main = '0; m_bst = '0; rb_exp = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R10: reset state
        check("R10 code",  32'(dac_code[31:0]), 32'h0);
        check("R10 ctrl",  32'(dac_ctrl[31:0]), 32'h0);
        check("R10 boost", 32'(boost_cfg), 32'h0);
        check("R10 miso",  32'(spi_miso), 32'h0);
        mon_en = 1'b1;

        // R3: data, gain and offset writes on each channel
        frame(mk(0, 5'h00, 16'h1234), 24);
        frame(mk(0, 5'h01, 16'hABCD), 24);
        frame(mk(0, 5'h02, 16'h8001), 24);
        frame(mk(0, 5'h03, 16'hFFFF), 24);
        frame(mk(0, 5'h08, 16'h7E7E), 24);
        frame(mk(0, 5'h0B, 16'h0101), 24);
        frame(mk(0, 5'h10, 16'hC3C3), 24);
        frame(mk(0, 5'h13, 16'h5A5A), 24);
        // R4: slew and output-control sub-registers
        frame(mk(0, 5'h1E, 16'h1A5A), 24);
        frame(mk(0, 5'h1D, 16'h41F6), 24);
        frame(mk(0, 5'h1F, 16'h4054), 24);
        // R5: shared words via different channel bits
        frame(mk(0, 5'h1F, 16'h2F0F), 24);
        frame(mk(0, 5'h1C, 16'h605B), 24);
        // R6: ignored selectors, unmapped writes, idle word
        frame(mk(0, 5'h1C, 16'h8FFF), 24);
        frame(mk(0, 5'h1D, 16'hA123), 24);
        frame(mk(0, 5'h1E, 16'hFFFF), 24);
        frame(mk(0, 5'h05, 16'h1111), 24);
        frame(mk(0, 5'h0C, 16'h2222), 24);
        frame(mk(0, 5'h15, 16'h3333), 24);
        frame(mk(0, 5'h18, 16'h4444), 24);
        frame(32'h001CE000, 24);
        // R7 / R8: read every address, chained
        for (int a = 0; a < 32; a++) frame(mk(1, 5'(a), 16'h0), 24);
        frame(32'h001CE000, 24);
        // R2: short and long words discarded, next word returns zero
        frame(mk(1, 5'h01, 16'h0), 24);
        frame(mk(0, 5'h00, 16'h5555), 23);
        frame(32'h001CE000, 24);
        frame({7'h0, 1'b1, mk(0, 5'h01, 16'h6666)}, 25);
        frame(mk(1, 5'h01, 16'h0), 24);
        frame(mk(0, 5'h00, 16'h9999), 24);
        frame(32'h001CE000, 24);
        // R1: bits 22:21 ignored
        frame(32'h00600000 | mk(0, 5'h02, 16'h2468), 24);
        // mixed traffic
        for (int k = 0; k < 60; k++) begin
            logic [31:0] r;
            r = $urandom;
            frame(mk(r[31], r[20:16], r[15:0]), 24);
        end
        frame(32'h001CE000, 24);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule